// File: doc/BRIEF.md
# ADC Sample and Conversion Sequencer

This block is the digital controller in front of a successive-approximation converter. Software programs a 16-bit control word. That word enables the module, picks the result resolution and output format, and chooses which event ends the sampling phase. The sequencer drives a sample-enable level to the analog front end. When the selected event arrives, it drops that level and issues a one-cycle convert-start strobe.

The event can be any of the following:
- software clearing the sample bit;
- an internal counter that runs for a programmed number of clocks;
- one of several external event inputs.

The converter answers with a conversion-complete pulse and a raw 12-bit code. The sequencer captures that code into a 16-bit result word, shaped as a 10- or 12-bit value. The value is unsigned or offset to signed, and placed right-justified or left-justified. The sequencer then sets a done flag. It can also re-arm sampling automatically, and it honours device idle and sleep states.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control word layout: bit 15 enable, bit 13 idle-stop, bit 10 12-bit mode, bits 9:8 format, bits 7:4 trigger select, bit 2 auto-sample, bit 1 sample, bit 0 done. All of these reset to 0, and bits 14, 12, 11 and 3 always read 0.
- R2: While enable is 0, the sample bit and `sample_en` stay 0 and no `conv_start` is issued, even if software writes 1 to the sample bit.
- R3: While `pwr_idle` is 1 and idle-stop is 1, `sample_en` is 0, triggers are ignored and the auto counter holds. With idle-stop 0, idle has no effect.
- R4: In 10-bit mode only raw bits 9:0 are used. In 12-bit mode raw bits 11:0 are used. Unsigned right-justified 10-bit results have bits 15:10 at 0.
- R5: Format codes:
  - 00: unsigned, right-justified.
  - 01: signed, right-justified, equal to raw minus half scale (512 or 2048), sign-extended.
  - 10: unsigned, left-justified with MSB at bit 15 and low bits 0.
  - 11: the signed value, left-justified.
- R6: With trigger select 0000, a software write that clears a set sample bit ends sampling. `conv_start` is then high for exactly one cycle, with `sample_en` low.
- R7: With trigger select 0111, `sample_en` stays high for exactly SAMPLE_CLKS cycles after sampling starts, and then `conv_start` pulses.
- R8: External trigger codes map to `evt_in` bits as follows:
  - codes 1–4 map to bits 0–3;
  - codes 5 and 6 both map to bit 4, the timer;
  - codes 8–12 map to bits 5–9.
  Code 5 fires only while `pwr_sleep` is 0. Code 6 fires only while `pwr_sleep` is 1.
- R9: Trigger codes 13–15 never start a conversion.
- R10: The done bit is set when a conversion completes. Writing 0 to it clears it, and writing 1 to it has no effect.
- R11: With auto-sample 1, the sample bit and `sample_en` return to 1 in the cycle the conversion completes.
- R12: A `conv_done` pulse while no conversion is in progress leaves the result and the done bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word write data |
| rd_data | output | 16 | Control word read-back |
| pwr_idle | input | 1 | Device is in idle |
| pwr_sleep | input | 1 | Device is in sleep |
| evt_in | input | 10 | External trigger events |
| conv_done | input | 1 | Conversion-complete pulse from the converter |
| raw_result | input | 12 | Raw converter code |
| sample_en | output | 1 | Sample-and-hold enable to the front end |
| conv_start | output | 1 | One-cycle convert-start strobe |
| result | output | 16 | Formatted conversion result |

## Verification
The bench walks every format code at both resolutions, including the half-scale and full-scale extremes. An offset or shift error there shows up as a wrong sign, a wrong low-bit fill or stray upper bits. Raw values with set upper bits are fed in 10-bit mode, so a design that forgot to mask them would leak them into the result.

The bench goes after the following corner cases:
- The two timer codes are driven in and out of sleep. A crossed sleep qualifier fires in the wrong power state.
- The reserved codes are held with every event active. A decoder that falls through to an event input would start conversions.
- The sampling window in auto mode is counted. An off-by-one in the counter gives one clock too many or too few.
- Stray completion pulses are applied, which a design without a busy guard would capture.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int WORD_W = 16;
    localparam int EVT_W  = 10;

    localparam logic [3:0] TRG_SOFT    = 4'd0;
    localparam logic [3:0] TRG_TMR_RUN = 4'd5;
    localparam logic [3:0] TRG_TMR_SLP = 4'd6;
    localparam logic [3:0] TRG_AUTO    = 4'd7;
    localparam logic [3:0] TRG_RSV_LO  = 4'd13;

    typedef struct packed {
        logic       en;
        logic       idle_stop;
        logic       mode12;
        logic [1:0] form;
        logic [3:0] trsel;
        logic       asam;
    } ctl_t;

    typedef struct packed {
        ctl_t              ctl;
        logic              sample;
        logic              done;
        logic              busy;
        logic              start;
        logic [WORD_W-1:0] result;
    } seq_state_t;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  logic [3:0]       sel,
    input  logic [EVT_W-1:0] evt,
    input  logic             sleep,
    input  logic             auto_expire,
    output logic             fire
);

    always_comb begin
        unique case (sel)
            4'd1:        fire = evt[0];
            4'd2:        fire = evt[1];
            4'd3:        fire = evt[2];
            4'd4:        fire = evt[3];
            TRG_TMR_RUN: fire = evt[4] & ~sleep;
            TRG_TMR_SLP: fire = evt[4] & sleep;
            TRG_AUTO:    fire = auto_expire;
            4'd8:        fire = evt[5];
            4'd9:        fire = evt[6];
            4'd10:       fire = evt[7];
            4'd11:       fire = evt[8];
            4'd12:       fire = evt[9];
            default:     fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_samp_timer.sv
module adc_samp_timer #(
    parameter int SAMPLE_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expire
);

    localparam int CW = (SAMPLE_CLKS > 1) ? $clog2(SAMPLE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expire = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run)
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
    parameter int RAW_W  = 12,
    parameter int WORD_W = 16
) (
    input  logic [RAW_W-1:0]  raw,
    input  logic              mode12,
    input  logic [1:0]        form,
    output logic [WORD_W-1:0] word
);

    localparam int NARROW = RAW_W - 2;
    localparam logic [WORD_W-1:0] HALF_W = WORD_W'(1) << (RAW_W - 1);
    localparam logic [WORD_W-1:0] HALF_N = WORD_W'(1) << (NARROW - 1);

    logic [WORD_W-1:0] ext, off, half;
    logic [4:0]        shamt;

    always_comb begin
        ext   = mode12 ? WORD_W'(raw) : WORD_W'(raw[NARROW-1:0]);
        half  = mode12 ? HALF_W : HALF_N;
        shamt = mode12 ? 5'(WORD_W - RAW_W) : 5'(WORD_W - NARROW);
        off   = ext - half;
        unique case (form)
            2'b00: word = ext;
            2'b01: word = off;
            2'b10: word = ext << shamt;
            default: word = off << shamt;
        endcase
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RAW_W       = 12,
    parameter int SAMPLE_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pwr_idle,
    input  logic              pwr_sleep,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic              conv_done,
    input  logic [RAW_W-1:0]  raw_result,
    output logic              sample_en,
    output logic              conv_start,
    output logic [WORD_W-1:0] result
);

    seq_state_t        q, d;
    logic              suspend, active, trig_fire, auto_expire;
    logic              tmr_run, tmr_clear, start;
    logic [WORD_W-1:0] fmt_word;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[14], wr_data[12:11], wr_data[3]};

    assign suspend   = pwr_idle && q.ctl.idle_stop;
    assign active    = q.ctl.en && !suspend;
    assign tmr_run   = q.sample && active && !q.busy && (q.ctl.trsel == TRG_AUTO);
    assign tmr_clear = !q.sample;

    adc_samp_timer #(.SAMPLE_CLKS(SAMPLE_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .clear  (tmr_clear),
        .expire (auto_expire)
    );

    adc_trig_sel u_trig (
        .sel         (q.ctl.trsel),
        .evt         (evt_in),
        .sleep       (pwr_sleep),
        .auto_expire (auto_expire),
        .fire        (trig_fire)
    );

    adc_res_fmt #(.RAW_W(RAW_W), .WORD_W(WORD_W)) u_fmt (
        .raw    (raw_result),
        .mode12 (q.ctl.mode12),
        .form   (q.ctl.form),
        .word   (fmt_word)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        start   = 1'b0;

        if (wr_en) begin
            d.ctl.en        = wr_data[15];
            d.ctl.idle_stop = wr_data[13];
            d.ctl.mode12    = wr_data[10];
            d.ctl.form      = wr_data[9:8];
            d.ctl.trsel     = wr_data[7:4];
            d.ctl.asam      = wr_data[2];
            d.sample        = wr_data[1];
            if (!wr_data[0])
                d.done = 1'b0;
            if (q.sample && !wr_data[1] && (q.ctl.trsel == TRG_SOFT) && active && !q.busy)
                start = 1'b1;
        end

        if (q.sample && active && !q.busy && trig_fire)
            start = 1'b1;

        if (start) begin
            d.sample = 1'b0;
            d.start  = 1'b1;
            d.busy   = 1'b1;
        end

        if (q.busy && conv_done) begin
            d.busy   = 1'b0;
            d.done   = 1'b1;
            d.result = fmt_word;
            if (q.ctl.asam)
                d.sample = 1'b1;
        end

        if (!d.ctl.en) begin
            d.sample = 1'b0;
            d.busy   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign rd_data    = {q.ctl.en, 1'b0, q.ctl.idle_stop, 2'b00, q.ctl.mode12, q.ctl.form,
                         q.ctl.trsel, 1'b0, q.ctl.asam, q.sample, q.done};
    assign sample_en  = q.sample && !suspend;
    assign conv_start = q.start;
    assign result     = q.result;

    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |=> !q.start);

    assert_start_ends_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> !q.sample);

    assert_start_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> $past(q.ctl.en));

    assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(conv_done && q.busy));

    assert_reserved_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctl.trsel >= TRG_RSV_LO && !wr_en && !q.busy) |=> !q.start);

    assert_narrow_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && conv_done && !q.ctl.mode12 && q.ctl.form == 2'b00)
            |=> (q.result[15:10] == '0));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SAMP       = 5;
    localparam int LAT        = 3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        pwr_idle = 0, pwr_sleep = 0;
    logic [9:0]  evt_in = '0;
    logic        stub_done = 0, man_done = 0;
    logic        conv_done;
    logic [11:0] raw_result = '0;
    logic        sample_en, conv_start;
    logic [15:0] result;

    int n_chk = 0, n_bad = 0;

    assign conv_done = stub_done | man_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(.RAW_W(12), .SAMPLE_CLKS(SAMP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pwr_idle(pwr_idle), .pwr_sleep(pwr_sleep), .evt_in(evt_in),
        .conv_done(conv_done), .raw_result(raw_result),
        .sample_en(sample_en), .conv_start(conv_start), .result(result)
    );

    // converter stub: fixed latency after each start strobe
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                repeat (LAT) @(negedge clk);
                stub_done = 1;
                @(negedge clk);
                stub_done = 0;
            end
        end
    end

    // {mode12, form, raw, expected}
    localparam logic [30:0] VECS [0:10] = '{
        {1'b0, 2'd0, 12'h3FF, 16'h03FF},
        {1'b0, 2'd1, 12'h000, 16'hFE00},
        {1'b0, 2'd1, 12'h3FF, 16'h01FF},
        {1'b0, 2'd2, 12'h3FF, 16'hFFC0},
        {1'b0, 2'd3, 12'h200, 16'h0000},
        {1'b0, 2'd3, 12'h000, 16'h8000},
        {1'b1, 2'd0, 12'hABC, 16'h0ABC},
        {1'b1, 2'd1, 12'h7FF, 16'hFFFF},
        {1'b1, 2'd2, 12'h123, 16'h1230},
        {1'b1, 2'd3, 12'hFFF, 16'h7FF0},
        {1'b0, 2'd0, 12'hC01, 16'h0001}
    };

    function automatic logic [15:0] mk(logic en, logic ids, logic m12, logic [1:0] fm,
                                       logic [3:0] ts, logic as, logic sp, logic dn);
        return {en, 1'b0, ids, 2'b00, m12, fm, ts, 1'b0, as, sp, dn};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk);
        wr_en = 1; wr_data = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_start(input int maxc, output logic got);
        got = 0;
        for (int i = 0; i < maxc; i++) begin
            if (conv_start) got = 1;
            @(negedge clk);
        end
    endtask

    task automatic wait_done(output logic got);
        got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (rd_data[0]) got = 1;
            else @(negedge clk);
        end
    endtask

    task automatic pulse_evt(input int idx);
        @(negedge clk);
        evt_in[idx] = 1;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %h expected %h", 16'h0, 16'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic got;
        logic [15:0] keep;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(rd_data == 16'h0, "R1 reset rd_data", rd_data, 16'h0);
        chk({sample_en, conv_start} == 2'b00 && result == 0, "R1 reset outputs",
            {sample_en, conv_start, result[13:0]}, 16'h0);

        // R1 layout / R10 done write-1 ignored / R9 reserved 15
        wr(16'hFFFF);
        chk(rd_data == 16'hA7F6, "R1 readback", rd_data, 16'hA7F6);
        evt_in = '1;
        wait_start(12, got);
        evt_in = '0;
        chk(!got, "R9 code 15 silent", {15'h0, got}, 16'h0);
        wr(mk(1, 0, 0, 2'd0, 4'd13, 0, 1, 0));
        evt_in = '1;
        wait_start(12, got);
        evt_in = '0;
        chk(!got && sample_en, "R9 code 13 silent", {14'h0, got, sample_en}, 16'h1);
        wr(16'h0);

        // R4 / R5 format table, software-clear trigger (R6), done set (R10)
        for (int v = 0; v < 11; v++) begin
            logic m12;
            logic [1:0] fm;
            m12 = VECS[v][30];
            fm  = VECS[v][29:28];
            raw_result = VECS[v][27:16];
            wr(mk(1, 0, m12, fm, 4'd0, 0, 1, 0));
            wr(mk(1, 0, m12, fm, 4'd0, 0, 0, 0));
            if (v == 0) begin
                chk(conv_start && !sample_en, "R6 start on sw clear",
                    {14'h0, conv_start, sample_en}, 16'h2);
                @(negedge clk);
                chk(!conv_start, "R6 start one cycle", {15'h0, conv_start}, 16'h0);
            end
            wait_done(got);
            chk(got, "R10 done set", {15'h0, got}, 16'h1);
            chk(result == VECS[v][15:0], "R5 format vector", result, VECS[v][15:0]);
        end

        // R10 done: write 1 keeps, write 0 clears, write 1 does not set
        wr(mk(1, 0, 0, 2'd0, 4'd0, 0, 0, 1));
        chk(rd_data[0], "R10 write 1 keeps done", rd_data, 16'h8001);
        wr(mk(1, 0, 0, 2'd0, 4'd0, 0, 0, 0));
        chk(!rd_data[0], "R10 write 0 clears", rd_data, 16'h8000);
        wr(mk(1, 0, 0, 2'd0, 4'd0, 0, 0, 1));
        chk(!rd_data[0], "R10 write 1 no set", rd_data, 16'h8000);

        // R12 stray completion ignored
        keep = result;
        raw_result = 12'h555;
        @(negedge clk); man_done = 1;
        @(negedge clk); man_done = 0;
        @(negedge clk);
        chk(result == keep && !rd_data[0], "R12 stray done", result, keep);

        // R2 disabled
        wr(mk(0, 0, 0, 2'd0, 4'd1, 0, 1, 0));
        chk(!rd_data[1] && !sample_en, "R2 sample blocked", rd_data, 16'h0010);
        pulse_evt(0);
        wait_start(6, got);
        chk(!got, "R2 no start when off", {15'h0, got}, 16'h0);

        // R8 external code 1
        wr(mk(1, 0, 0, 2'd0, 4'd1, 0, 1, 0));
        pulse_evt(0);
        wait_start(3, got);
        chk(got, "R8 code 1 evt0", {15'h0, got}, 16'h1);
        wait_done(got);
        // R8 code 12
        wr(mk(1, 0, 0, 2'd0, 4'd12, 0, 1, 0));
        pulse_evt(8);
        wait_start(3, got);
        chk(!got, "R8 code 12 ignores evt8", {15'h0, got}, 16'h0);
        pulse_evt(9);
        wait_start(3, got);
        chk(got, "R8 code 12 evt9", {15'h0, got}, 16'h1);
        wait_done(got);

        // R8 timer codes vs sleep
        pwr_sleep = 1;
        wr(mk(1, 0, 0, 2'd0, 4'd5, 0, 1, 0));
        pulse_evt(4);
        wait_start(4, got);
        chk(!got, "R8 code 5 blocked in sleep", {15'h0, got}, 16'h0);
        wr(mk(1, 0, 0, 2'd0, 4'd6, 0, 1, 0));
        pulse_evt(4);
        wait_start(3, got);
        chk(got, "R8 code 6 fires in sleep", {15'h0, got}, 16'h1);
        wait_done(got);
        pwr_sleep = 0;
        wr(mk(1, 0, 0, 2'd0, 4'd6, 0, 1, 0));
        pulse_evt(4);
        wait_start(4, got);
        chk(!got, "R8 code 6 blocked awake", {15'h0, got}, 16'h0);
        wr(mk(1, 0, 0, 2'd0, 4'd5, 0, 1, 0));
        pulse_evt(4);
        wait_start(3, got);
        chk(got, "R8 code 5 fires awake", {15'h0, got}, 16'h1);
        wait_done(got);

        // R3 idle stop
        pwr_idle = 1;
        wr(mk(1, 1, 0, 2'd0, 4'd1, 0, 1, 0));
        chk(!sample_en, "R3 sample_en off in idle", {15'h0, sample_en}, 16'h0);
        pulse_evt(0);
        wait_start(4, got);
        chk(!got, "R3 trigger held in idle", {15'h0, got}, 16'h0);
        wr(mk(1, 0, 0, 2'd0, 4'd1, 0, 1, 0));
        chk(sample_en, "R3 idle ignored when clear", {15'h0, sample_en}, 16'h1);
        pulse_evt(0);
        wait_start(3, got);
        chk(got, "R3 runs in idle", {15'h0, got}, 16'h1);
        wait_done(got);
        pwr_idle = 0;

        // R7 auto counter window
        wr(mk(1, 0, 0, 2'd0, 4'd7, 0, 1, 0));
        n = 0;
        for (int i = 0; i < 30 && !conv_start; i++) begin
            if (sample_en) n++;
            @(negedge clk);
        end
        chk(n == SAMP && conv_start, "R7 sample window", 16'(n), 16'(SAMP));
        wait_done(got);

        // R11 auto-sample rearm
        wr(mk(1, 0, 0, 2'd0, 4'd0, 1, 1, 0));
        wr(mk(1, 0, 0, 2'd0, 4'd0, 1, 0, 0));
        wait_done(got);
        chk(got && rd_data[1] && sample_en, "R11 rearm", rd_data, 16'h8007);
        wr(16'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule